// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Engine

This block is a single-port synchronous memory with its own storage array (256 words of two 9-bit bytes by default). It takes one read or one write command on every enabled clock edge. Reads and writes may alternate freely, with no idle cycle when the data bus changes direction. Write data arrives a fixed number of enabled edges after its command, and that distance matches the read latency. As a result, a read command and a write command take the same number of bus cycles.

A static pin, `flow_mode`, is captured while reset is held and selects one of two timing modes:

- **Pipelined:** read data is registered for one more edge, and write data is taken two enabled edges after the command.
- **Flow-through:** read data appears right after the command edge, and write data is taken on the next enabled edge.

Writes whose data has not yet been committed wait in a two-entry stage pipeline. In pipelined mode, a read that collides with the write whose data is arriving gets the merged, forwarded word.

The controller's state machine has two states. `ST_PIPE` is entered by the transition "reset with flow_mode low". `ST_FLOW` is entered by the transition "reset with flow_mode high". Both states have only a self-loop until the next reset.

Each of the two command stages moves between three slot states:

- `SLOT_IDLE`: deselect, advance, or no command.
- `SLOT_READ`: a read command.
- `SLOT_WRITE`: a write command.

On each enabled edge, the "load" transition moves a newly decoded command into the first stage and moves the first stage into the second. A stalled edge takes the "hold" transition, and nothing moves.

Top module: `zt_sram_engine`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `dq_oe` is low and `dq_out` is zero until a read result becomes valid.
- R2: In pipelined mode (`flow_mode` low at reset), the data of a read command is presented after the next enabled edge following the command edge.
- R3: In pipelined mode, the write data for a command is sampled from `dq_in` at the second enabled edge after the command edge.
- R4: In flow-through mode (`flow_mode` high at reset), the data of a read command is presented right after its command edge, and the write data is sampled at the next enabled edge.
- R5: Reads and writes may alternate on consecutive enabled edges with no idle cycle. A read always returns the word as updated by every earlier write command, including writes whose data is still in flight.
- R6: `bw_n` bit i low enables byte i, which is `dq_in[9i+8:9i]`. Any subset of bytes may be written, and a write with every `bw_n` bit high leaves the memory unchanged.
- R7: The device is selected only when all three `ce_n` bits are low. With any bit high, the edge carries no command: no write happens and no read result is produced.
- R8: `adv_ld` high at a command edge is treated as a deselect, exactly as in R7. A command is loaded only with `adv_ld` low.
- R9: With `cke_n` high at an edge, every internal stage and the outputs hold their values, and `dq_in` is ignored, as if the edge had not occurred.
- R10: `dq_oe` is high only while a read result is valid and `oe_n` is low, and it follows `oe_n` without waiting for a clock. `dq_out` reads zero when no read result is valid.
- R11: `flow_mode` is sampled only during reset. Changing it while running does not alter the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling is on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flow_mode | input | 1 | Timing select captured in reset: 1 for flow-through, 0 for pipelined |
| cke_n | input | 1 | Clock enable, active low; high stalls the whole block |
| ce_n | input | 3 | Three chip selects, active low; all must be low to select |
| adv_ld | input | 1 | 0 loads a new command; 1 is treated as a deselect |
| we_n | input | 1 | 0 for a write command, 1 for a read command |
| bw_n | input | BYTES | Byte write enables, active low, one per 9-bit byte |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Output enable, active low, acts combinationally |
| dq_in | input | BYTES*BYTE_W | Write data from the shared bus |
| dq_out | output | BYTES*BYTE_W | Read data toward the shared bus, zero when no result is valid |
| dq_oe | output | 1 | Bus driver enable for `dq_out` |

## Verification
If a write slot were misplaced in the stage pipeline, the word would be stored with the data from the wrong bus cycle. That fault shows at the ports on the first later read of that address, typically two or three cycles later in the alternating streams. A broken forwarding path or a wrong read stage shows on the very read that follows a write to the same address: `dq_out` is then off in the cycle its result appears. A stage that fails to hold under a clock-enable stall makes `dq_out` or `dq_oe` change during the stalled cycle itself. A mode latch that follows the pin mid-run shifts every read by one cycle within one command.

// File: rtl/zt_pkg.sv
package zt_pkg;

    // Content of one command stage
    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_READ  = 2'd1,
        SLOT_WRITE = 2'd2
    } slot_e;

    // Timing mode, fixed from reset onward
    typedef enum logic {
        ST_PIPE = 1'b0,
        ST_FLOW = 1'b1
    } mode_e;

endpackage

// File: rtl/zt_cmd_decode.sv
module zt_cmd_decode
    import zt_pkg::*;
#(
    parameter int N_CE  = 3,
    parameter int BYTES = 2
) (
    input  logic [N_CE-1:0]  ce_n,
    input  logic             adv_ld,
    input  logic             we_n,
    input  logic [BYTES-1:0] bw_n,
    output slot_e            kind,
    output logic [BYTES-1:0] be
);

    logic selected;

    always_comb begin
        selected = ~(|ce_n);
        if (!selected || adv_ld) begin
            kind = SLOT_IDLE;
        end else if (we_n) begin
            kind = SLOT_READ;
        end else begin
            kind = SLOT_WRITE;
        end
        be = ~bw_n;
    end

endmodule

// File: rtl/zt_pipe_ctrl.sv
module zt_pipe_ctrl
    import zt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_mode,
    input  logic              cke_n,
    input  slot_e             cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [BYTES-1:0]  cmd_be,
    output logic              mode_flow,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_live,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTES-1:0]  wr_be,
    output logic              fwd_hit,
    output logic [BYTES-1:0]  fwd_be
);

    mode_e             state_q;
    slot_e             s1_kind, s2_kind;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [BYTES-1:0]  s1_be, s2_be;

    // State register: the mode is chosen only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= flow_mode ? ST_FLOW : ST_PIPE;
        end
    end

    // Command stages: load on an enabled edge, hold on a stalled one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_kind <= SLOT_IDLE;
            s2_kind <= SLOT_IDLE;
            s1_addr <= '0;
            s2_addr <= '0;
            s1_be   <= '0;
            s2_be   <= '0;
        end else if (!cke_n) begin
            s1_kind <= cmd_kind;
            s1_addr <= cmd_addr;
            s1_be   <= cmd_be;
            s2_kind <= s1_kind;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
        end
    end

    // Outputs per state
    always_comb begin
        mode_flow = 1'b0;
        rd_addr   = s1_addr;
        rd_live   = (s1_kind == SLOT_READ);
        wr_en     = 1'b0;
        wr_addr   = s2_addr;
        wr_be     = s2_be;
        fwd_hit   = 1'b0;
        fwd_be    = s2_be;
        unique case (state_q)
            ST_FLOW: begin
                mode_flow = 1'b1;
                wr_en     = !cke_n && (s1_kind == SLOT_WRITE);
                wr_addr   = s1_addr;
                wr_be     = s1_be;
            end
            ST_PIPE: begin
                wr_en     = !cke_n && (s2_kind == SLOT_WRITE);
                fwd_hit   = (s2_kind == SLOT_WRITE) && (s2_addr == s1_addr);
            end
        endcase
    end

endmodule

// File: rtl/zt_array.sv
module zt_array #(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [BYTES-1:0]        wr_be,
    input  logic [BYTES*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [BYTES*BYTE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[b]) begin
                cells[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
            end
        end

        assign rd_data[b*BYTE_W +: BYTE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/zt_read_path.sv
module zt_read_path #(
    parameter int BYTES  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    mode_flow,
    input  logic                    rd_live,
    input  logic [BYTES*BYTE_W-1:0] arr_data,
    input  logic [BYTES*BYTE_W-1:0] bus_data,
    input  logic                    fwd_hit,
    input  logic [BYTES-1:0]        fwd_be,
    input  logic                    oe_n,
    output logic [BYTES*BYTE_W-1:0] dq_out,
    output logic                    dq_oe
);

    localparam int DATA_W = BYTES * BYTE_W;

    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] rdq;
    logic              rvld;
    logic              valid_now;
    logic [DATA_W-1:0] data_now;

    // Forward bytes of the write whose data is on the bus this edge
    for (genvar b = 0; b < BYTES; b++) begin : g_merge
        assign merged[b*BYTE_W +: BYTE_W] = (fwd_hit && fwd_be[b])
                                          ? bus_data[b*BYTE_W +: BYTE_W]
                                          : arr_data[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvld <= 1'b0;
            rdq  <= '0;
        end else if (!cke_n) begin
            rvld <= rd_live;
            rdq  <= merged;
        end
    end

    always_comb begin
        valid_now = mode_flow ? rd_live : rvld;
        data_now  = mode_flow ? arr_data : rdq;
        dq_out    = valid_now ? data_now : '0;
        dq_oe     = valid_now && !oe_n;
    end

endmodule

// File: rtl/zt_sram_engine.sv
module zt_sram_engine
    import zt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 9,
    parameter int N_CE   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flow_mode,
    input  logic                    cke_n,
    input  logic [N_CE-1:0]         ce_n,
    input  logic                    adv_ld,
    input  logic                    we_n,
    input  logic [BYTES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    oe_n,
    input  logic [BYTES*BYTE_W-1:0] dq_in,
    output logic [BYTES*BYTE_W-1:0] dq_out,
    output logic                    dq_oe
);

    localparam int DATA_W = BYTES * BYTE_W;

    slot_e             cmd_kind;
    logic [BYTES-1:0]  cmd_be;
    logic              mode_flow;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_live;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTES-1:0]  wr_be;
    logic              fwd_hit;
    logic [BYTES-1:0]  fwd_be;
    logic [DATA_W-1:0] arr_data;

    zt_cmd_decode #(.N_CE(N_CE), .BYTES(BYTES)) u_dec (
        .ce_n   (ce_n),
        .adv_ld (adv_ld),
        .we_n   (we_n),
        .bw_n   (bw_n),
        .kind   (cmd_kind),
        .be     (cmd_be)
    );

    zt_pipe_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flow_mode (flow_mode),
        .cke_n     (cke_n),
        .cmd_kind  (cmd_kind),
        .cmd_addr  (addr),
        .cmd_be    (cmd_be),
        .mode_flow (mode_flow),
        .rd_addr   (rd_addr),
        .rd_live   (rd_live),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_be     (wr_be),
        .fwd_hit   (fwd_hit),
        .fwd_be    (fwd_be)
    );

    zt_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_arr (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_be   (wr_be),
        .wr_data (dq_in),
        .rd_addr (rd_addr),
        .rd_data (arr_data)
    );

    zt_read_path #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke_n     (cke_n),
        .mode_flow (mode_flow),
        .rd_live   (rd_live),
        .arr_data  (arr_data),
        .bus_data  (dq_in),
        .fwd_hit   (fwd_hit),
        .fwd_be    (fwd_be),
        .oe_n      (oe_n),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
    parameter int DATA_W = 18,
    parameter int N_CE   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_n,
    input logic [N_CE-1:0]   ce_n,
    input logic              adv_ld,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [DATA_W-1:0] dq_out,
    input logic              mode_flow
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !dq_oe);                                           // R1

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> $stable(dq_out));                                   // R9

    AST_DESELECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_flow && !cke_n && (|ce_n)) |=> (dq_out == '0));         // R7

    AST_ADVANCE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_flow && !cke_n && adv_ld) |=> (dq_out == '0));          // R8

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);                                             // R10

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_flow));                                // R11

endmodule

bind zt_sram_engine zt_sram_chk #(.DATA_W(BYTES*BYTE_W), .N_CE(N_CE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke_n     (cke_n),
    .ce_n      (ce_n),
    .adv_ld    (adv_ld),
    .oe_n      (oe_n),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out),
    .mode_flow (mode_flow)
);

// File: tb/sim_zt_sram_engine.sv
module sim_zt_sram_engine;

    localparam int AW    = 8;
    localparam int NB    = 2;
    localparam int BW    = 9;
    localparam int DW    = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flow_mode = 1'b0;
    logic          cke_n = 1'b0;
    logic [2:0]    ce_n = 3'b111;
    logic          adv_ld = 1'b0;
    logic          we_n = 1'b1;
    logic [NB-1:0] bw_n = '0;
    logic [AW-1:0] addr = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    always #2 clk = ~clk;

    zt_sram_engine u0 (
        .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .cke_n(cke_n),
        .ce_n(ce_n), .adv_ld(adv_ld), .we_n(we_n), .bw_n(bw_n), .addr(addr),
        .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    int    total = 0;
    int    bad = 0;
    string cur_tag = "R1";

    // Behavioural reference: memory image plus queue of writes awaiting data
    logic [DW-1:0] ref_mem [DEPTH];
    int            q_left [$];
    logic [AW-1:0] q_addr [$];
    logic [NB-1:0] q_be   [$];
    logic [DW-1:0] q_data [$];
    bit            model_flow = 1'b0;
    bit            pend_rd = 1'b0;
    logic [AW-1:0] pend_addr = '0;
    bit            exp_v = 1'b0;
    logic [DW-1:0] exp_d = '0;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset(bit fm);
        @(negedge clk);
        rst_n = 1'b0; flow_mode = fm; cke_n = 1'b0; ce_n = 3'b111;
        adv_ld = 1'b0; we_n = 1'b1; bw_n = '0; addr = '0; oe_n = 1'b0;
        repeat (3) @(negedge clk);
        q_left.delete(); q_addr.delete(); q_be.delete(); q_data.delete();
        pend_rd = 1'b0; exp_v = 1'b0; model_flow = fm;
        rst_n = 1'b1;
        #1;
        check("R1", "dq_oe after reset", 32'(dq_oe), 32'd0);
        check("R1", "dq_out after reset", 32'(dq_out), 32'd0);
    endtask

    // One bus cycle: drive, compare outputs, then advance the model at the edge
    task automatic cyc(bit ck, logic [2:0] ce, bit adv, bit we, logic [NB-1:0] bw,
                       logic [AW-1:0] a, bit oe, logic [DW-1:0] wdat);
        bit sel, is_rd, is_wr;
        @(negedge clk);
        cke_n = ck; ce_n = ce; adv_ld = adv; we_n = we; bw_n = bw; addr = a; oe_n = oe;
        if (!ck && q_left.size() > 0 && q_left[0] == 1) dq_in = q_data[0];
        else dq_in = DW'($urandom);
        #1;
        check(cur_tag, "dq_oe", 32'(dq_oe), 32'(exp_v && !oe));
        if (exp_v) check(cur_tag, "dq_out", 32'(dq_out), 32'(exp_d));
        else       check(cur_tag, "dq_out idle", 32'(dq_out), 32'd0);
        @(posedge clk);
        if (!ck) begin
            sel   = (ce == 3'b000) && !adv;
            is_rd = sel && we;
            is_wr = sel && !we;
            foreach (q_left[i]) q_left[i]--;
            if (q_left.size() > 0 && q_left[0] == 0) begin
                for (int b = 0; b < NB; b++)
                    if (q_be[0][b]) ref_mem[q_addr[0]][b*BW +: BW] = q_data[0][b*BW +: BW];
                void'(q_left.pop_front()); void'(q_addr.pop_front());
                void'(q_be.pop_front());   void'(q_data.pop_front());
            end
            if (model_flow) begin
                exp_v = is_rd; exp_d = ref_mem[a];
            end else begin
                exp_v = pend_rd; exp_d = ref_mem[pend_addr];
                pend_rd = is_rd; pend_addr = a;
            end
            if (is_wr) begin
                q_left.push_back(model_flow ? 1 : 2);
                q_addr.push_back(a);
                q_be.push_back(~bw);
                q_data.push_back(wdat);
            end
        end
    endtask

    task automatic run(int n, int stall, int desel, int advp, int oeh, int part, bit alt, int arange);
        bit            next_wr = 1'b1;
        logic [AW-1:0] last_a = '0;
        repeat (n) begin
            bit            ck = ($urandom % 100) < stall;
            logic [2:0]    ce = (($urandom % 100) < desel) ? 3'($urandom % 7 + 1) : 3'b000;
            bit            adv = ($urandom % 100) < advp;
            bit            oe = ($urandom % 100) < oeh;
            logic [NB-1:0] bw = (($urandom % 100) < part) ? NB'($urandom) : '0;
            bit            we;
            logic [AW-1:0] a;
            if (alt) begin
                we = !next_wr;
                a  = next_wr ? AW'($urandom % arange) : last_a;
            end else begin
                we = 1'($urandom % 2);
                a  = AW'($urandom % arange);
            end
            cyc(ck, ce, adv, we, bw, a, oe, DW'($urandom));
            if (alt && !ck) begin
                if (next_wr) last_a = a;
                next_wr = !next_wr;
            end
        end
    endtask

    initial begin
        do_reset(1'b0);
        cur_tag = "R3";                       // pipelined writes fill the array
        for (int i = 0; i < DEPTH; i++) cyc(0, 3'b000, 0, 0, '0, AW'(i), 0, DW'($urandom));
        cur_tag = "R2";  run(200, 0, 0, 0, 0, 0, 0, 256);
        cur_tag = "R3";  run(200, 0, 0, 0, 0, 0, 0, 4);
        cur_tag = "R5";  run(300, 0, 0, 0, 0, 0, 1, 8);
        cur_tag = "R9";  run(300, 30, 0, 0, 0, 0, 1, 8);
        cur_tag = "R6";  run(300, 10, 0, 0, 0, 60, 0, 8);
        cur_tag = "R7";  run(300, 10, 40, 0, 0, 20, 0, 8);
        cur_tag = "R8";  run(300, 10, 0, 40, 0, 0, 0, 8);
        cur_tag = "R10"; run(300, 10, 0, 0, 40, 0, 0, 8);
        cur_tag = "R11"; flow_mode = 1'b1; run(300, 20, 10, 10, 10, 20, 1, 8);

        do_reset(1'b1);
        cur_tag = "R4";  run(300, 0, 0, 0, 0, 0, 0, 16);
        cur_tag = "R5";  run(300, 0, 0, 0, 0, 0, 1, 8);
        cur_tag = "R9";  run(300, 30, 0, 0, 0, 0, 1, 8);
        cur_tag = "R6";  run(300, 10, 0, 0, 0, 60, 0, 8);
        cur_tag = "R7";  run(200, 10, 40, 0, 0, 20, 0, 8);
        cur_tag = "R8";  run(200, 10, 0, 40, 0, 0, 0, 8);
        cur_tag = "R10"; run(200, 10, 0, 0, 40, 0, 0, 8);
        cur_tag = "R11"; flow_mode = 1'b0; run(300, 20, 10, 10, 10, 20, 1, 8);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL %s watchdog actual=running expected=finished", cur_tag);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule